// File: doc/BRIEF.md
# Raster Timing Generator with Shift-Register Counters

This block produces horizontal sync, vertical sync and a display-enable strobe for a raster display, one pixel per clock. Its horizontal and vertical position counters are 16-bit linear feedback shift registers rather than binary adders. A shift register needs no carry chain, so the next-state logic stays a single XOR deep whatever the counter width.

Every timing threshold is given as the shift-register state that the counter reaches a chosen number of clocks after its all-ones seed. Each threshold is compared for equality with the running state, so the block decodes no counts. Only the two active-area sizes are plain binary numbers, which cap the number of pixels and lines shown inside the display window. For observation, the block also drives the horizontal and vertical position as binary step counts.

Configuration is sampled into a shadow copy only while the generator is held or at the end of a frame. A frame is therefore always built from one consistent set of settings. A two-bit mode input selects normal output, blanked video with running syncs, or power-down.

Top module: `rasterTimingLfsr`

## Requirements
- R1: While `rstN` is low, and for the first clock cycle after it rises, `hSync`, `vSync` and `dispEn` are low and `pixX` and `pixY` read 0.
- R2: Each counter starts from 16'hFFFF. Each step shifts the state left by one bit and fills bit 0 with the XOR of bits 15, 4, 2 and 1 of the old state. A threshold written as "count N" is the state reached after N steps from the seed, and `pixX` reads the number of steps taken in the current line.
- R3: In the cycle where the horizontal state equals `hLineEnd`, the next cycle starts a new line at the seed (`pixX` = 0). A line therefore lasts N+1 clocks when `hLineEnd` encodes count N.
- R4: At each line end the vertical counter takes one step and `pixY` increments. When that step would reach the state in `vFrameEnd`, the vertical counter returns to the seed instead (`pixY` = 0). A frame therefore has N lines when `vFrameEnd` encodes count N.
- R5: `hSync` is high from the clock where the horizontal state equals `hSyncOn` (inclusive) up to the clock where it equals `hSyncOff` (exclusive).
- R6: `vSync` is high for the lines from the `vSyncOn` state (inclusive) to the `vSyncOff` state (exclusive) of the vertical counter.
- R7: `dispEn` is high only inside both the horizontal window [`hDispOn`, `hDispOff`) and the vertical window [`vDispOn`, `vDispOff`).
- R8: Inside those windows, `dispEn` is further limited to the first `hActive` pixels of the horizontal window and the first `vActive` lines of the vertical window. Both limits are plain binary values.
- R9: The mode takes effect one clock after it is sampled. Mode encoding: 0 = normal, 1 = blank, 2 or 3 = power-down. In blank mode the syncs keep running and `dispEn` is low.
- R10: In power-down all three outputs are low. From the second clock of power-down onward, both counters are held at the seed (`pixX` = `pixY` = 0). On leaving power-down, a fresh frame starts from position 0.
- R11: Threshold and size inputs are sampled only during a held cycle (reset release, power-down) or at a frame end. A change in mid-frame first affects the frame that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blankMode | input | 2 | 0 normal, 1 blank, 2/3 power-down |
| hLineEnd | input | 16 | Encoded last horizontal count of a line |
| hSyncOn | input | 16 | Encoded horizontal sync start |
| hSyncOff | input | 16 | Encoded horizontal sync end (exclusive) |
| hDispOn | input | 16 | Encoded horizontal display start |
| hDispOff | input | 16 | Encoded horizontal display end (exclusive) |
| hActive | input | 16 | Binary pixels shown per line |
| vFrameEnd | input | 16 | Encoded vertical total (lines per frame) |
| vSyncOn | input | 16 | Encoded vertical sync start |
| vSyncOff | input | 16 | Encoded vertical sync end (exclusive) |
| vDispOn | input | 16 | Encoded vertical display start |
| vDispOff | input | 16 | Encoded vertical display end (exclusive) |
| vActive | input | 16 | Binary lines shown per frame |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| dispEn | output | 1 | Display enable |
| pixX | output | 16 | Binary horizontal position |
| pixY | output | 16 | Binary vertical position |

## Verification
The bench builds the block with its default 16-bit counter width and the fixed tap set. It programs tiny rasters: 24 × 10 and 20 × 8 clocks. With these, whole frames, frame-end wrap, and several frames of both settings fit into a few thousand cycles. The first setting makes both active-size limits shorter than their windows, so the clipping path is exercised. The second makes them longer, so the windows alone bound the display area. A mid-frame change of setting and the mode sequence blank, power-down, code 3, normal each fall inside reach of the frame-sized runs.

// File: rtl/rasterTimingPkg.sv
package rasterTimingPkg;

  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] SEED = {CNT_W{1'b1}};
  // feedback taps: bits 15, 4, 2, 1
  localparam logic [CNT_W-1:0] TAPS = 16'h8016;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_BLANK = 2'd1,
    MODE_OFF   = 2'd2,
    MODE_OFF2  = 2'd3
  } tgMode_t;

  typedef struct packed {
    cnt_t hLineEnd;
    cnt_t hSyncOn;
    cnt_t hSyncOff;
    cnt_t hDispOn;
    cnt_t hDispOff;
    cnt_t hActive;
    cnt_t vFrameEnd;
    cnt_t vSyncOn;
    cnt_t vSyncOff;
    cnt_t vDispOn;
    cnt_t vDispOff;
    cnt_t vActive;
  } tgCfg_t;

  typedef struct packed {
    logic hold;
    logic lineEnd;
    logic frameEnd;
    logic blankDe;
  } tgStrobe_t;

  function automatic cnt_t lfsrStep(input cnt_t s);
    return {s[CNT_W-2:0], ^(s & TAPS)};
  endfunction

endpackage

// File: rtl/tgWindow.sv
module tgWindow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         update,
  input  logic [W-1:0] state,
  input  logic [W-1:0] onThr,
  input  logic [W-1:0] offThr,
  output logic         active
);

  logic winQ;

  // open on the start state, stay open until the end state is reached
  always_comb begin
    active = (state == onThr) | (winQ & (state != offThr));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winQ <= 1'b0;
    end else if (clear) begin
      winQ <= 1'b0;
    end else if (update) begin
      winQ <= active;
    end
  end

endmodule

// File: rtl/tgControl.sv
module tgControl
  import rasterTimingPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] blankMode,
  input  tgCfg_t    cfgIn,
  input  logic      lineMatch,
  input  logic      frameMatch,
  output tgStrobe_t strb,
  output tgCfg_t    cfgQ
);

  logic    pendQ;
  tgMode_t modeQ;
  logic    hold;
  logic    loadCfg;

  always_comb begin
    hold          = pendQ | (modeQ == MODE_OFF) | (modeQ == MODE_OFF2);
    strb.hold     = hold;
    strb.lineEnd  = !hold & lineMatch;
    strb.frameEnd = !hold & lineMatch & frameMatch;
    strb.blankDe  = (modeQ == MODE_BLANK);
    loadCfg       = hold | strb.frameEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b1;
      modeQ <= MODE_RUN;
    end else begin
      pendQ <= 1'b0;
      modeQ <= tgMode_t'(blankMode);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (loadCfg) begin
      cfgQ <= cfgIn;
    end
  end

  // settings never change inside a running frame
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.hold && !strb.frameEnd) |=> $stable(cfgQ));

endmodule

// File: rtl/tgDatapath.sv
module tgDatapath
  import rasterTimingPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  tgStrobe_t strb,
  input  tgCfg_t    cfg,
  output logic      lineMatch,
  output logic      frameMatch,
  output logic      hSync,
  output logic      vSync,
  output logic      dispEn,
  output cnt_t      pixX,
  output cnt_t      pixY
);

  localparam int NUM_WIN  = 4;
  localparam int WIN_HSYN = 0;
  localparam int WIN_HDSP = 1;
  localparam int WIN_VSYN = 2;
  localparam int WIN_VDSP = 3;

  cnt_t hLfsr, vLfsr;
  cnt_t hAct, vAct;
  cnt_t vNext;

  cnt_t winOn  [NUM_WIN];
  cnt_t winOff [NUM_WIN];
  cnt_t winSt  [NUM_WIN];
  logic winClr [NUM_WIN];
  logic winUpd [NUM_WIN];
  logic winAct [NUM_WIN];

  always_comb begin
    vNext      = lfsrStep(vLfsr);
    lineMatch  = (hLfsr == cfg.hLineEnd);
    frameMatch = (vNext == cfg.vFrameEnd);

    winOn[WIN_HSYN]  = cfg.hSyncOn;
    winOff[WIN_HSYN] = cfg.hSyncOff;
    winOn[WIN_HDSP]  = cfg.hDispOn;
    winOff[WIN_HDSP] = cfg.hDispOff;
    winOn[WIN_VSYN]  = cfg.vSyncOn;
    winOff[WIN_VSYN] = cfg.vSyncOff;
    winOn[WIN_VDSP]  = cfg.vDispOn;
    winOff[WIN_VDSP] = cfg.vDispOff;
  end

  // horizontal windows follow every pixel, vertical ones every line
  generate
    for (genvar i = 0; i < NUM_WIN; i++) begin : gWin
      localparam bit IS_H = (i == WIN_HSYN) || (i == WIN_HDSP);
      always_comb begin
        winSt[i]  = IS_H ? hLfsr : vLfsr;
        winClr[i] = strb.hold | (IS_H ? strb.lineEnd : strb.frameEnd);
        winUpd[i] = IS_H ? 1'b1 : strb.lineEnd;
      end
      tgWindow #(.W(CNT_W)) uWin (
        .clk    (clk),
        .rstN   (rstN),
        .clear  (winClr[i]),
        .update (winUpd[i]),
        .state  (winSt[i]),
        .onThr  (winOn[i]),
        .offThr (winOff[i]),
        .active (winAct[i])
      );
    end
  endgenerate

  // horizontal counter and its binary mirrors
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hLfsr <= SEED;
      pixX  <= '0;
      hAct  <= '0;
    end else if (strb.hold || strb.lineEnd) begin
      hLfsr <= SEED;
      pixX  <= '0;
      hAct  <= '0;
    end else begin
      hLfsr <= lfsrStep(hLfsr);
      pixX  <= pixX + 1'b1;
      if (winAct[WIN_HDSP]) hAct <= hAct + 1'b1;
    end
  end

  // vertical counter and its binary mirrors
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vLfsr <= SEED;
      pixY  <= '0;
      vAct  <= '0;
    end else if (strb.hold || strb.frameEnd) begin
      vLfsr <= SEED;
      pixY  <= '0;
      vAct  <= '0;
    end else if (strb.lineEnd) begin
      vLfsr <= vNext;
      pixY  <= pixY + 1'b1;
      if (winAct[WIN_VDSP]) vAct <= vAct + 1'b1;
    end
  end

  always_comb begin
    hSync  = winAct[WIN_HSYN] & !strb.hold;
    vSync  = winAct[WIN_VSYN] & !strb.hold;
    dispEn = winAct[WIN_HDSP] & winAct[WIN_VDSP]
           & (hAct < cfg.hActive) & (vAct < cfg.vActive)
           & !strb.hold & !strb.blankDe;
  end

  // an all-ones seeded register with bit 15 in the feedback never reaches zero
  assert_lfsr_live_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hLfsr != '0) && (vLfsr != '0));

  assert_line_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.lineEnd |=> (hLfsr == SEED) && (pixX == '0));

  assert_frame_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameEnd |=> (vLfsr == SEED) && (pixY == '0));

  assert_hold_seed_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.hold |=> (pixX == '0) && (pixY == '0));

endmodule

// File: rtl/rasterTimingLfsr.sv
module rasterTimingLfsr
  import rasterTimingPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  blankMode,
  input  logic [15:0] hLineEnd,
  input  logic [15:0] hSyncOn,
  input  logic [15:0] hSyncOff,
  input  logic [15:0] hDispOn,
  input  logic [15:0] hDispOff,
  input  logic [15:0] hActive,
  input  logic [15:0] vFrameEnd,
  input  logic [15:0] vSyncOn,
  input  logic [15:0] vSyncOff,
  input  logic [15:0] vDispOn,
  input  logic [15:0] vDispOff,
  input  logic [15:0] vActive,
  output logic        hSync,
  output logic        vSync,
  output logic        dispEn,
  output logic [15:0] pixX,
  output logic [15:0] pixY
);

  tgCfg_t    cfgIn, cfgQ;
  tgStrobe_t strb;
  logic      lineMatch, frameMatch;

  always_comb begin
    cfgIn.hLineEnd  = hLineEnd;
    cfgIn.hSyncOn   = hSyncOn;
    cfgIn.hSyncOff  = hSyncOff;
    cfgIn.hDispOn   = hDispOn;
    cfgIn.hDispOff  = hDispOff;
    cfgIn.hActive   = hActive;
    cfgIn.vFrameEnd = vFrameEnd;
    cfgIn.vSyncOn   = vSyncOn;
    cfgIn.vSyncOff  = vSyncOff;
    cfgIn.vDispOn   = vDispOn;
    cfgIn.vDispOff  = vDispOff;
    cfgIn.vActive   = vActive;
  end

  tgControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .blankMode  (blankMode),
    .cfgIn      (cfgIn),
    .lineMatch  (lineMatch),
    .frameMatch (frameMatch),
    .strb       (strb),
    .cfgQ       (cfgQ)
  );

  tgDatapath uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfg        (cfgQ),
    .lineMatch  (lineMatch),
    .frameMatch (frameMatch),
    .hSync      (hSync),
    .vSync      (vSync),
    .dispEn     (dispEn),
    .pixX       (pixX),
    .pixY       (pixY)
  );

  assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    blankMode[1] |=> (!hSync && !vSync && !dispEn));

  assert_blank_de_R9: assert property (@(posedge clk) disable iff (!rstN)
    (blankMode == 2'd1) |=> !dispEn);

endmodule

// File: tb/test_rasterTimingLfsr.sv
module test_rasterTimingLfsr;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  blankMode = 2'd0;
  logic [15:0] hLineEnd = '0, hSyncOn = '0, hSyncOff = '0, hDispOn = '0, hDispOff = '0, hActive = '0;
  logic [15:0] vFrameEnd = '0, vSyncOn = '0, vSyncOff = '0, vDispOn = '0, vDispOff = '0, vActive = '0;
  logic        hSync, vSync, dispEn;
  logic [15:0] pixX, pixY;

  rasterTimingLfsr i_rasterTimingLfsr (
    .clk(clk), .rstN(rstN), .blankMode(blankMode),
    .hLineEnd(hLineEnd), .hSyncOn(hSyncOn), .hSyncOff(hSyncOff),
    .hDispOn(hDispOn), .hDispOff(hDispOff), .hActive(hActive),
    .vFrameEnd(vFrameEnd), .vSyncOn(vSyncOn), .vSyncOff(vSyncOff),
    .vDispOn(vDispOn), .vDispOff(vDispOff), .vActive(vActive),
    .hSync(hSync), .vSync(vSync), .dispEn(dispEn), .pixX(pixX), .pixY(pixY)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        hs;
    logic        vs;
    logic        de;
    logic [15:0] x;
    logic [15:0] y;
  } exp_t;

  exp_t  q[$];
  int    nChecks = 0;
  int    nFails = 0;
  int    cycles = 0;
  string phaseTag = "R1";
  bit    done = 1'b0;

  // binary live settings and model shadow: htot hss hse hds hde ha vtot vss vse vds vde va
  int live[12];
  int sh[12];
  int hc = 0, vc = 0, mMode = 0;
  bit pend = 1'b1;

  function automatic logic [15:0] enc(input int n);
    logic [15:0] s = 16'hFFFF;
    for (int k = 0; k < n; k++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  task automatic applyCfg(input int htot, hss, hse, hds, hde, ha,
                          input int vtot, vss, vse, vds, vde, va);
    live[0] = htot; live[1] = hss; live[2] = hse; live[3] = hds; live[4] = hde; live[5] = ha;
    live[6] = vtot; live[7] = vss; live[8] = vse; live[9] = vds; live[10] = vde; live[11] = va;
    hLineEnd  = enc(htot - 1);
    hSyncOn   = enc(hss);  hSyncOff = enc(hse);
    hDispOn   = enc(hds);  hDispOff = enc(hde);
    hActive   = 16'(ha);
    vFrameEnd = enc(vtot);
    vSyncOn   = enc(vss);  vSyncOff = enc(vse);
    vDispOn   = enc(vds);  vDispOff = enc(vde);
    vActive   = 16'(va);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s (phase %s) at cycle %0d: actual %0d expected %0d", tag, phaseTag, cycles, act, exp);
    end
  endtask

  // reference model: advances at each edge and pushes the outputs expected afterwards
  always @(posedge clk) begin
    exp_t e;
    bit   holdNow;
    cycles++;
    if (!rstN) begin
      pend = 1'b1; hc = 0; vc = 0; mMode = 0;
    end else begin
      if (pend || mMode >= 2) begin
        hc = 0; vc = 0; sh = live;
      end else if (hc == sh[0] - 1) begin
        hc = 0;
        if (vc + 1 == sh[6]) begin vc = 0; sh = live; end
        else vc++;
      end else begin
        hc++;
      end
      pend  = 1'b0;
      mMode = int'(blankMode);
    end
    holdNow = pend || mMode >= 2;
    e.hs = !holdNow && hc >= sh[1] && hc < sh[2];
    e.vs = !holdNow && vc >= sh[7] && vc < sh[8];
    e.de = !holdNow && mMode == 0
        && hc >= sh[3] && hc < sh[4] && (hc - sh[3]) < sh[5]
        && vc >= sh[9] && vc < sh[10] && (vc - sh[9]) < sh[11];
    e.x = 16'(hc);
    e.y = 16'(vc);
    q.push_back(e);
  end

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check("R5 hSync", int'(hSync), int'(e.hs));
      check("R6 vSync", int'(vSync), int'(e.vs));
      check("R7,R8 dispEn", int'(dispEn), int'(e.de));
      check("R2,R3 pixX", int'(pixX), int'(e.x));
      check("R4 pixY", int'(pixY), int'(e.y));
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired (phase %s)", phaseTag);
      finishRun();
    end
  end

  initial begin
    sh = '{default: 0};
    // setting A: both active sizes shorter than their windows
    applyCfg(24, 1, 4, 6, 18, 10, 10, 0, 2, 3, 8, 4);
    phaseTag = "R1";
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    phaseTag = "R3";
    repeat (100) @(negedge clk);
    phaseTag = "R8";
    repeat (400) @(negedge clk);
    // setting B applied mid-frame, windows bound the area
    phaseTag = "R11";
    applyCfg(20, 1, 3, 5, 15, 16, 8, 0, 1, 2, 7, 9);
    repeat (500) @(negedge clk);
    phaseTag = "R9";
    blankMode = 2'd1;
    repeat (200) @(negedge clk);
    phaseTag = "R10";
    blankMode = 2'd2;
    repeat (50) @(negedge clk);
    blankMode = 2'd3;
    repeat (20) @(negedge clk);
    blankMode = 2'd0;
    repeat (350) @(negedge clk);
    phaseTag = "R1";
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (60) @(negedge clk);
    done = 1'b1;
    finishRun();
  end

endmodule